// File: doc/BRIEF.md
# Instruction Skip-Mask Sequencer

This sequencer sits between instruction fetch and execute in a small processor. A skip instruction loads a mask. Each later instruction slot then consumes mask bits, one bit per instruction, starting at the least significant bit. A bit value of 1 means that instruction is skipped. For each slot the block tells fetch one of two things. It may say to leap over a run of skipped instructions, so that the program counter advances by `leap_cnt + 1` and costs no clocks. Otherwise it may say to cancel the instruction in the slot, which then passes as a two-clock no-operation.

A run of up to seven skipped instructions is free. The eighth skipped instruction in a row is cancelled, and counting then starts again. If the first instruction under a fresh mask is skipped, that instruction is always cancelled. A call-depth counter pauses all skipping while code runs inside a subroutine. Loading a new mask at any time replaces the single mask register and clears that counter. Taken branches do not touch the sequencer: mask consumption simply carries on with the instructions at the branch target.

There are two load variants. The fast load takes all 32 mask bits. The execute-and-skip load keeps only the low 22 bits.

Top module: `skip_seq`

## Requirements
- R1: Mask bits are consumed least-significant first, and a 1 means skip. `skip_busy` is high exactly while the remaining mask is non-zero. With an empty mask, every slot executes (`leap_cnt`=0, `cancel_nop`=0).
- R2: `load_fast` stores all 32 bits of `mask_in`. `load_exec` stores only bits 21:0 and clears bits 31:22. If both are asserted, `load_fast` wins.
- R3: When the current run has k skipped instructions (1 ≤ k ≤ 7) followed by an executed one, a single slot reports `leap_cnt`=k and `cancel_nop`=0, and consumes k+1 bits.
- R4: When eight or more 1 bits are pending, the slot reports `leap_cnt`=7 and `cancel_nop`=1, and consumes 8 bits. The run count then restarts, so 8–15 skips cost one no-operation, 16–23 cost two and 24–31 cost three.
- R5: On the first slot after a load, a mask bit 0 of 1 gives `cancel_nop`=1 with `leap_cnt`=0 and consumes one bit. Up to 7 further skips are then free.
- R6: An executed instruction ends the run, so the next slot again has a full allowance of 7 free skips.
- R7: While the call depth is non-zero, slots report `leap_cnt`=0 and `cancel_nop`=0, and no mask bits are consumed.
- R8: `call_in` raises the call depth by one and `ret_in` lowers it by one. Skipping resumes with the stored mask once the depth is back to zero.
- R9: A load while the depth is non-zero replaces the mask, clears the depth to zero and re-arms the first-instruction rule of R5.
- R10: The 4-bit call depth saturates: after 16 calls it holds at 15, and a return at depth 0 leaves it at 0.
- R11: With `slot_adv` low, `leap_cnt` is 0 and `cancel_nop` is 0, and no mask bits are consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_fast | input | 1 | Load all mask bits from `mask_in` |
| load_exec | input | 1 | Load the low 22 bits of `mask_in` |
| mask_in | input | 32 | Skip mask (bit 0 applies to the next instruction) |
| call_in | input | 1 | A subroutine call was executed |
| ret_in | input | 1 | A subroutine return was executed |
| slot_adv | input | 1 | An instruction slot is being decided this cycle |
| leap_cnt | output | 3 | Skipped instructions passed over before this slot |
| cancel_nop | output | 1 | The instruction in this slot is cancelled as a no-operation |
| skip_busy | output | 1 | Unconsumed skip bits remain |

## Verification
Masks are chosen so that the length of the run of 1 bits falls on each pricing boundary: short runs of 2 and 7, runs of 15 and 16, and runs of 21 and 31 under both load variants. Together they separate free leaps from forced no-operations and show the truncation to 22 bits. A mask whose bit 0 is set distinguishes the first-instruction cancel from an ordinary leap. Call and return sequences around a part-consumed mask show that the pause keeps the mask intact. A reload inside a call and a depth pushed beyond 15 show whether the counter is cleared or saturates, and whether it wraps by mistake.

// File: rtl/skip_seq_pkg.sv
package skip_seq_pkg;

    localparam int DEF_MASK_W   = 32;
    localparam int DEF_EXEC_W   = 22;
    localparam int DEF_DEPTH_W  = 4;
    localparam int DEF_LEAP_MAX = 7;

    typedef enum logic [1:0] {
        DEPTH_HOLD  = 2'd0,
        DEPTH_UP    = 2'd1,
        DEPTH_DOWN  = 2'd2,
        DEPTH_CLEAR = 2'd3
    } depth_act_e;

    function automatic depth_act_e depth_action(logic ld, logic call, logic ret);
        if (ld)                return DEPTH_CLEAR;
        else if (call && !ret) return DEPTH_UP;
        else if (ret && !call) return DEPTH_DOWN;
        else                   return DEPTH_HOLD;
    endfunction

endpackage

// File: rtl/skip_seq_depth.sv
module skip_seq_depth
    import skip_seq_pkg::*;
#(
    parameter int DEPTH_W = DEF_DEPTH_W
) (
    input  logic               clk,
    input  logic               rst,
    input  depth_act_e         act,
    output logic [DEPTH_W-1:0] depth_q,
    output logic               depth_zero
);
    localparam logic [DEPTH_W-1:0] DEPTH_TOP = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            depth_q <= '0;
        end else begin
            unique case (act)
                DEPTH_CLEAR: depth_q <= '0;
                DEPTH_UP:    if (depth_q != DEPTH_TOP) depth_q <= depth_q + 1'b1;
                DEPTH_DOWN:  if (depth_q != '0) depth_q <= depth_q - 1'b1;
                default:     depth_q <= depth_q;
            endcase
        end
    end

    assign depth_zero = (depth_q == '0);
endmodule

// File: rtl/skip_seq_step.sv
module skip_seq_step #(
    parameter int LEAP_MAX = 7,
    parameter int LEAP_W   = $clog2(LEAP_MAX + 1),
    parameter int RUN_LIM  = LEAP_MAX + 1,
    parameter int CONS_W   = $clog2(RUN_LIM + 1)
) (
    input  logic [RUN_LIM-1:0] low_bits,
    input  logic               first_pend,
    input  logic               depth_zero,
    input  logic               slot_adv,
    output logic [LEAP_W-1:0]  leap,
    output logic               cancel,
    output logic [CONS_W-1:0]  consume
);
    logic [CONS_W-1:0] run;
    logic              stop;

    always_comb begin
        run  = '0;
        stop = 1'b0;
        for (int i = 0; i < RUN_LIM; i++) begin
            if (!stop && low_bits[i]) begin
                run = run + 1'b1;
            end else begin
                stop = 1'b1;
            end
        end
    end

    always_comb begin
        leap    = '0;
        cancel  = 1'b0;
        consume = '0;
        if (slot_adv && depth_zero) begin
            if (first_pend && low_bits[0]) begin
                cancel  = 1'b1;
                consume = CONS_W'(1);
            end else if (run == CONS_W'(RUN_LIM)) begin
                leap    = LEAP_W'(LEAP_MAX);
                cancel  = 1'b1;
                consume = CONS_W'(RUN_LIM);
            end else begin
                leap    = run[LEAP_W-1:0];
                consume = run + 1'b1;
            end
        end
    end
endmodule

// File: rtl/skip_seq_mask.sv
module skip_seq_mask #(
    parameter int MASK_W = 32,
    parameter int EXEC_W = 22,
    parameter int CONS_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_fast,
    input  logic              load_exec,
    input  logic [MASK_W-1:0] mask_in,
    input  logic [CONS_W-1:0] consume,
    output logic [MASK_W-1:0] mask_q,
    output logic              first_q
);
    localparam logic [MASK_W-1:0] EXEC_KEEP = {{(MASK_W-EXEC_W){1'b0}}, {EXEC_W{1'b1}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            first_q <= 1'b0;
        end else if (load_fast) begin
            mask_q  <= mask_in;
            first_q <= 1'b1;
        end else if (load_exec) begin
            mask_q  <= mask_in & EXEC_KEEP;
            first_q <= 1'b1;
        end else if (consume != '0) begin
            mask_q  <= mask_q >> consume;
            first_q <= 1'b0;
        end
    end
endmodule

// File: rtl/skip_seq.sv
module skip_seq
    import skip_seq_pkg::*;
#(
    parameter int MASK_W   = DEF_MASK_W,
    parameter int EXEC_W   = DEF_EXEC_W,
    parameter int DEPTH_W  = DEF_DEPTH_W,
    parameter int LEAP_MAX = DEF_LEAP_MAX
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              load_fast,
    input  logic                              load_exec,
    input  logic [MASK_W-1:0]                 mask_in,
    input  logic                              call_in,
    input  logic                              ret_in,
    input  logic                              slot_adv,
    output logic [$clog2(LEAP_MAX+1)-1:0]     leap_cnt,
    output logic                              cancel_nop,
    output logic                              skip_busy
);
    localparam int LEAP_W  = $clog2(LEAP_MAX + 1);
    localparam int RUN_LIM = LEAP_MAX + 1;
    localparam int CONS_W  = $clog2(RUN_LIM + 1);

    logic [MASK_W-1:0]  mask_q;
    logic               first_q;
    logic [DEPTH_W-1:0] depth_q;
    logic               depth_zero;
    logic [CONS_W-1:0]  consume;
    logic               any_load;
    depth_act_e         act;

    assign any_load = load_fast | load_exec;
    assign act      = depth_action(any_load, call_in, ret_in);

    skip_seq_depth #(.DEPTH_W(DEPTH_W)) u_depth (
        .clk        (clk),
        .rst        (rst),
        .act        (act),
        .depth_q    (depth_q),
        .depth_zero (depth_zero)
    );

    skip_seq_step #(
        .LEAP_MAX (LEAP_MAX),
        .LEAP_W   (LEAP_W),
        .RUN_LIM  (RUN_LIM),
        .CONS_W   (CONS_W)
    ) u_step (
        .low_bits   (mask_q[RUN_LIM-1:0]),
        .first_pend (first_q),
        .depth_zero (depth_zero),
        .slot_adv   (slot_adv),
        .leap       (leap_cnt),
        .cancel     (cancel_nop),
        .consume    (consume)
    );

    skip_seq_mask #(
        .MASK_W (MASK_W),
        .EXEC_W (EXEC_W),
        .CONS_W (CONS_W)
    ) u_mask (
        .clk       (clk),
        .rst       (rst),
        .load_fast (load_fast),
        .load_exec (load_exec),
        .mask_in   (mask_in),
        .consume   (consume),
        .mask_q    (mask_q),
        .first_q   (first_q)
    );

    assign skip_busy = (mask_q != '0);
endmodule

// File: rtl/skip_seq_chk.sv
module skip_seq_chk #(
    parameter int MASK_W  = 32,
    parameter int EXEC_W  = 22,
    parameter int DEPTH_W = 4,
    parameter int LEAP_W  = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               load_fast,
    input logic               load_exec,
    input logic               call_in,
    input logic               ret_in,
    input logic               slot_adv,
    input logic [LEAP_W-1:0]  leap_cnt,
    input logic               cancel_nop,
    input logic               skip_busy,
    input logic [MASK_W-1:0]  mask_q,
    input logic [DEPTH_W-1:0] depth_q
);
    localparam logic [DEPTH_W-1:0] TOP = '1;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !slot_adv |-> (leap_cnt == '0 && !cancel_nop)); // R11

    AST_EMPTY_EXECUTES: assert property (@(posedge clk) disable iff (rst)
        !skip_busy |-> (leap_cnt == '0 && !cancel_nop)); // R1

    AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (depth_q != '0) |-> (leap_cnt == '0 && !cancel_nop)); // R7

    AST_PAUSE_HOLDS_MASK: assert property (@(posedge clk) disable iff (rst)
        (depth_q != '0 && !load_fast && !load_exec) |=> $stable(mask_q)); // R7

    AST_LOAD_CLEARS_DEPTH: assert property (@(posedge clk) disable iff (rst)
        (load_fast || load_exec) |=> (depth_q == '0)); // R9

    AST_EXEC_TRUNCATES: assert property (@(posedge clk) disable iff (rst)
        (load_exec && !load_fast) |=> (mask_q[MASK_W-1:EXEC_W] == '0)); // R2

    AST_DEPTH_SAT_TOP: assert property (@(posedge clk) disable iff (rst)
        (depth_q == TOP && call_in && !ret_in && !load_fast && !load_exec) |=> (depth_q == TOP)); // R10

    AST_DEPTH_SAT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (depth_q == '0 && ret_in && !call_in) |=> (depth_q == '0)); // R10
endmodule

bind skip_seq skip_seq_chk #(
    .MASK_W  (MASK_W),
    .EXEC_W  (EXEC_W),
    .DEPTH_W (DEPTH_W),
    .LEAP_W  (LEAP_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .load_fast  (load_fast),
    .load_exec  (load_exec),
    .call_in    (call_in),
    .ret_in     (ret_in),
    .slot_adv   (slot_adv),
    .leap_cnt   (leap_cnt),
    .cancel_nop (cancel_nop),
    .skip_busy  (skip_busy),
    .mask_q     (mask_q),
    .depth_q    (depth_q)
);

// File: tb/skip_seq_tb.sv
module skip_seq_tb;
    localparam logic [2:0] OP_LF = 3'd0;
    localparam logic [2:0] OP_LX = 3'd1;
    localparam logic [2:0] OP_ST = 3'd2;
    localparam logic [2:0] OP_CA = 3'd3;
    localparam logic [2:0] OP_RE = 3'd4;

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] data;
        logic [2:0]  leap;
        logic        nop;
    } vec_t;

    localparam int NV = 55;
    localparam vec_t VEC [NV] = '{
        // R1 R3: bits 1,2 -> execute, then leap 2
        '{OP_LF, 32'h0000_0006, 3'd0, 1'b0},
        '{OP_ST, 32'h0, 3'd0, 1'b0},
        '{OP_ST, 32'h0, 3'd2, 1'b0},
        '{OP_ST, 32'h0, 3'd0, 1'b0},
        // R5: first instruction skipped -> cancel
        '{OP_LF, 32'h0000_0001, 3'd0, 1'b0},
        '{OP_ST, 32'h0, 3'd0, 1'b1},
        '{OP_ST, 32'h0, 3'd0, 1'b0},
        // R4 R6: run of 15 -> one nop
        '{OP_LF, 32'h0000_FFFE, 3'd0, 1'b0},
        '{OP_ST, 32'h0, 3'd0, 1'b0},
        '{OP_ST, 32'h0, 3'd7, 1'b1},
        '{OP_ST, 32'h0, 3'd7, 1'b0},
        '{OP_ST, 32'h0, 3'd0, 1'b0},
        // R4: run of 16 -> two nops
        '{OP_LF, 32'h0001_FFFE, 3'd0, 1'b0},
        '{OP_ST, 32'h0, 3'd0, 1'b0},
        '{OP_ST, 32'h0, 3'd7, 1'b1},
        '{OP_ST, 32'h0, 3'd7, 1'b1},
        '{OP_ST, 32'h0, 3'd0, 1'b0},
        // R5: first skipped + 7 more -> one nop
        '{OP_LF, 32'h0000_00FF, 3'd0, 1'b0},
        '{OP_ST, 32'h0, 3'd0, 1'b1},
        '{OP_ST, 32'h0, 3'd7, 1'b0},
        '{OP_ST, 32'h0, 3'd0, 1'b0},
        // R7 R8: nested calls pause skipping
        '{OP_LF, 32'h0000_0016, 3'd0, 1'b0},
        '{OP_ST, 32'h0, 3'd0, 1'b0},
        '{OP_CA, 32'h0, 3'd0, 1'b0},
        '{OP_ST, 32'h0, 3'd0, 1'b0},
        '{OP_CA, 32'h0, 3'd0, 1'b0},
        '{OP_ST, 32'h0, 3'd0, 1'b0},
        '{OP_RE, 32'h0, 3'd0, 1'b0},
        '{OP_ST, 32'h0, 3'd0, 1'b0},
        '{OP_RE, 32'h0, 3'd0, 1'b0},
        '{OP_ST, 32'h0, 3'd2, 1'b0},
        '{OP_ST, 32'h0, 3'd1, 1'b0},
        // R9 R10: reload inside call; return at depth 0 saturates
        '{OP_LF, 32'h0000_0006, 3'd0, 1'b0},
        '{OP_ST, 32'h0, 3'd0, 1'b0},
        '{OP_CA, 32'h0, 3'd0, 1'b0},
        '{OP_LF, 32'h0000_0003, 3'd0, 1'b0},
        '{OP_ST, 32'h0, 3'd0, 1'b1},
        '{OP_ST, 32'h0, 3'd1, 1'b0},
        '{OP_LF, 32'h0000_0002, 3'd0, 1'b0},
        '{OP_RE, 32'h0, 3'd0, 1'b0},
        '{OP_ST, 32'h0, 3'd0, 1'b0},
        '{OP_ST, 32'h0, 3'd1, 1'b0},
        // R2: execute variant keeps 22 bits -> 21 ones
        '{OP_LX, 32'hFFFF_FFFE, 3'd0, 1'b0},
        '{OP_ST, 32'h0, 3'd0, 1'b0},
        '{OP_ST, 32'h0, 3'd7, 1'b1},
        '{OP_ST, 32'h0, 3'd7, 1'b1},
        '{OP_ST, 32'h0, 3'd5, 1'b0},
        '{OP_ST, 32'h0, 3'd0, 1'b0},
        // R2 R4: fast variant, 31 ones -> three nops
        '{OP_LF, 32'hFFFF_FFFE, 3'd0, 1'b0},
        '{OP_ST, 32'h0, 3'd0, 1'b0},
        '{OP_ST, 32'h0, 3'd7, 1'b1},
        '{OP_ST, 32'h0, 3'd7, 1'b1},
        '{OP_ST, 32'h0, 3'd7, 1'b1},
        '{OP_ST, 32'h0, 3'd7, 1'b0},
        '{OP_ST, 32'h0, 3'd0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_fast = 1'b0, load_exec = 1'b0;
    logic [31:0] mask_in = '0;
    logic        call_in = 1'b0, ret_in = 1'b0, slot_adv = 1'b0;
    logic [2:0]  leap_cnt;
    logic        cancel_nop, skip_busy;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    skip_seq u_dut (
        .clk(clk), .rst(rst), .load_fast(load_fast), .load_exec(load_exec),
        .mask_in(mask_in), .call_in(call_in), .ret_in(ret_in),
        .slot_adv(slot_adv), .leap_cnt(leap_cnt), .cancel_nop(cancel_nop),
        .skip_busy(skip_busy)
    );

    task automatic check(string req, logic [3:0] act, logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Drive one operation at the falling edge, check the combinational slot
    // outputs before the rising edge that commits it.
    task automatic apply(logic [2:0] op, logic [31:0] data, string req,
                         logic [2:0] el, logic en);
        @(negedge clk);
        load_fast = (op == OP_LF);
        load_exec = (op == OP_LX);
        mask_in   = data;
        call_in   = (op == OP_CA);
        ret_in    = (op == OP_RE);
        slot_adv  = (op == OP_ST);
        #1;
        check(req, {leap_cnt, cancel_nop}, {el, en});
        @(posedge clk);
    endtask

    task automatic quiet();
        @(negedge clk);
        {load_fast, load_exec, call_in, ret_in, slot_adv} = '0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state is an empty mask; a slot simply executes
        slot_adv = 1'b1;
        #1;
        check("R1 reset busy", {3'd0, skip_busy}, 4'd0);
        check("R1 reset slot", {leap_cnt, cancel_nop}, 4'd0);
        @(posedge clk);
        quiet();

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i].op, VEC[i].data, "R3/R4/R5 vector", VEC[i].leap, VEC[i].nop);
        end
        quiet();
        // R1: sequence ended, nothing pending
        #1;
        check("R1 end busy", {3'd0, skip_busy}, 4'd0);

        // R11: no slot -> no consumption, mask still busy
        apply(OP_LF, 32'h0000_0001, "R11 load", 3'd0, 1'b0);
        quiet();
        repeat (3) @(posedge clk);
        #1;
        check("R11 idle busy", {3'd0, skip_busy}, 4'd1);
        check("R11 idle out", {leap_cnt, cancel_nop}, 4'd0);
        apply(OP_ST, 32'h0, "R11 then R5", 3'd0, 1'b1);

        // R10: 16 calls saturate at 15, 15 returns needed
        apply(OP_LF, 32'h0000_0001, "R10 load", 3'd0, 1'b0);
        for (int k = 0; k < 16; k++) apply(OP_CA, 32'h0, "R10 call", 3'd0, 1'b0);
        apply(OP_ST, 32'h0, "R10 no wrap", 3'd0, 1'b0);
        for (int k = 0; k < 14; k++) apply(OP_RE, 32'h0, "R10 ret", 3'd0, 1'b0);
        apply(OP_ST, 32'h0, "R10 still paused", 3'd0, 1'b0);
        apply(OP_RE, 32'h0, "R10 ret last", 3'd0, 1'b0);
        apply(OP_ST, 32'h0, "R10 R8 resumed", 3'd0, 1'b1);
        quiet();
        #1;
        check("R1 drained", {3'd0, skip_busy}, 4'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule